// File: doc/BRIEF.md
# Embedded Operation Status Responder

This block sits on the read path of a byte-wide non-volatile memory. While an internal program or erase sequence runs, the host cannot see array contents; instead every read returns a status word in which the operation state is carried inside the data bits. The top bit is a polling bit: it is the inverse of the top bit of the byte being programmed, or zero during an erase. The next bit down is a toggle bit that changes value on every read. All lower bits are released (drive enable low). When the controller drops its busy flag, reads return normal array data again with all bits driven.

The controller upstream raises `op_busy` only once the second write of a two-write command sequence has completed, so status is presented exactly while that flag is high. A host decides completion by seeing the toggle bit hold still over two consecutive reads and the polling bit match the expected value. Each read is requested with a one-cycle `rd_strobe`; the resulting bus value and per-bit drive enables appear on the next clock edge and are held until the next strobe.

The control is a three-state machine. `ST_IDLE` (no operation) moves to `ST_PROG` when `op_busy` is seen with `op_is_erase` low, or to `ST_ERASE` when it is seen with `op_is_erase` high; in that same transition the kind and the top bit of the written byte are captured. `ST_PROG` and `ST_ERASE` each return to `ST_IDLE` on the first cycle `op_busy` is low, and otherwise stay where they are.

Top module: `poll_status_responder`

## Requirements
- R1: During and directly after reset, `bus_q` and `bus_oe` are all zero.
- R2: A strobe in a cycle with `op_busy` low makes the next cycle show `bus_q` equal to the `arr_data` sampled with the strobe, with `bus_oe` all ones.
- R3: For a program operation, a strobe while `op_busy` is high yields bit 7 equal to the inverse of `wr_top_bit` as sampled in the cycle `op_busy` was first seen; later changes of `wr_top_bit` have no effect until the operation ends.
- R4: For an erase operation, a strobe while `op_busy` is high yields bit 7 equal to 0.
- R5: While `op_busy` is high, bit 6 of successive status reads is 0, 1, 0, 1, ...; it advances only on strobes, however many idle cycles lie between them.
- R6: A status read drives bits 7 and 6 (`bus_oe` = 0xC0) and returns 0 on bits 5 to 0, regardless of `arr_data`.
- R7: The operation kind (`op_is_erase`: 0 program, 1 erase) is sampled when `op_busy` is first seen; changing it during the operation does not change the status.
- R8: A strobe in any cycle with `op_busy` low after an operation returns array data with all bits driven, so two consecutive reads show bit 6 steady and bit 7 at its true value.
- R9: Each new operation starts its toggle sequence at 0, whatever the count of reads in the previous one; a strobe in the very first busy cycle already returns status.
- R10: Without a strobe, `bus_q` and `bus_oe` keep their values, even if `arr_data` changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_busy | input | 1 | Internal program or erase sequence running |
| op_is_erase | input | 1 | Operation kind: 0 program, 1 erase |
| wr_top_bit | input | 1 | Bit 7 of the byte last written for programming |
| rd_strobe | input | 1 | One-cycle read request |
| arr_data | input | 8 | Array read data |
| bus_q | output | 8 | Read data presented to the host |
| bus_oe | output | 8 | Per-bit drive enable for `bus_q` |

## Verification
A program with written top bit 0 and one with top bit 1 separate a correct inversion from a constant polling bit. Erase reads taken with and without dozens of idle cycles between them tell a strobe-driven toggle from a clock-driven one, and flipping `op_is_erase` and `wr_top_bit` mid-operation shows whether they are sampled once or followed live. Reads right after the busy flag falls, with patterns such as 0x3C and 0xFF, show that all eight bits return driven, while a restart after an odd number of status reads shows whether the toggle is cleared between operations.

// File: rtl/poll_resp_pkg.sv
package poll_resp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PROG  = 2'd1,
        ST_ERASE = 2'd2
    } resp_state_t;

endpackage

// File: rtl/poll_resp_capture.sv
// Holds the operation kind and the top bit of the written byte for the
// whole length of an operation.
module poll_resp_capture (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic kind_in,
    input  logic top_in,
    output logic kind_held,
    output logic top_held
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_held <= 1'b0;
            top_held  <= 1'b0;
        end else if (load) begin
            kind_held <= kind_in;
            top_held  <= top_in;
        end
    end

endmodule

// File: rtl/poll_resp_toggle.sv
// Read-driven toggle: cleared whenever no operation runs, advances once
// per status read only.
module poll_resp_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic advance,
    output logic tog
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tog <= 1'b0;
        end else if (!active) begin
            tog <= 1'b0;
        end else if (advance) begin
            tog <= ~tog;
        end
    end

endmodule

// File: rtl/poll_resp_format.sv
// Builds the word and drive enables for one read.
module poll_resp_format #(
    parameter int W = 8
) (
    input  logic         show_status,
    input  logic         is_erase,
    input  logic         top_bit,
    input  logic         tog,
    input  logic [W-1:0] arr_data,
    output logic [W-1:0] word,
    output logic [W-1:0] drive
);

    localparam int POLL_POS = W - 1;
    localparam int TOG_POS  = W - 2;

    logic poll_val;

    always_comb begin
        poll_val = is_erase ? 1'b0 : ~top_bit;
    end

    for (genvar gi = 0; gi < W; gi++) begin : g_bit
        if (gi == POLL_POS) begin : g_poll
            always_comb begin
                word[gi]  = show_status ? poll_val : arr_data[gi];
                drive[gi] = 1'b1;
            end
        end else if (gi == TOG_POS) begin : g_tog
            always_comb begin
                word[gi]  = show_status ? tog : arr_data[gi];
                drive[gi] = 1'b1;
            end
        end else begin : g_rel
            always_comb begin
                word[gi]  = show_status ? 1'b0 : arr_data[gi];
                drive[gi] = ~show_status;
            end
        end
    end

endmodule

// File: rtl/poll_status_responder.sv
module poll_status_responder
    import poll_resp_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         op_busy,
    input  logic         op_is_erase,
    input  logic         wr_top_bit,
    input  logic         rd_strobe,
    input  logic [W-1:0] arr_data,
    output logic [W-1:0] bus_q,
    output logic [W-1:0] bus_oe
);

    resp_state_t state;
    resp_state_t state_nxt;

    logic         kind_held;
    logic         top_held;
    logic         tog;
    logic         cap_load;
    logic         eff_kind;
    logic         eff_top;
    logic [W-1:0] fmt_word;
    logic [W-1:0] fmt_drive;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    // transitions
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (op_busy) begin
                    state_nxt = op_is_erase ? ST_ERASE : ST_PROG;
                end
            end
            ST_PROG: begin
                if (!op_busy) begin
                    state_nxt = ST_IDLE;
                end
            end
            ST_ERASE: begin
                if (!op_busy) begin
                    state_nxt = ST_IDLE;
                end
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    // In the first busy cycle the live inputs are used; afterwards the
    // captured copies.
    always_comb begin
        cap_load = (state == ST_IDLE) && op_busy;
        eff_kind = (state == ST_IDLE) ? op_is_erase : kind_held;
        eff_top  = (state == ST_IDLE) ? wr_top_bit  : top_held;
    end

    poll_resp_capture u_capture (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (cap_load),
        .kind_in   (op_is_erase),
        .top_in    (wr_top_bit),
        .kind_held (kind_held),
        .top_held  (top_held)
    );

    poll_resp_toggle u_toggle (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (op_busy),
        .advance (rd_strobe),
        .tog     (tog)
    );

    poll_resp_format #(.W(W)) u_format (
        .show_status (op_busy),
        .is_erase    (eff_kind),
        .top_bit     (eff_top),
        .tog         (tog),
        .arr_data    (arr_data),
        .word        (fmt_word),
        .drive       (fmt_drive)
    );

    // output register, loaded once per read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_q  <= '0;
            bus_oe <= '0;
        end else if (rd_strobe) begin
            bus_q  <= fmt_word;
            bus_oe <= fmt_drive;
        end
    end

endmodule

// File: rtl/poll_resp_checker.sv
module poll_resp_checker
    import poll_resp_pkg::*;
#(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         op_busy,
    input logic         rd_strobe,
    input logic [W-1:0] arr_data,
    input logic [W-1:0] bus_q,
    input logic [W-1:0] bus_oe,
    input resp_state_t  state,
    input logic         tog,
    input logic         top_held
);

    always @(posedge clk) begin
        if (!rst_n) begin
            #1;
            assert_reset_clear_R1: assert (bus_q == '0 && bus_oe == '0);
        end
    end

    assert_idle_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && !op_busy) |=> (bus_oe == '1 && bus_q == $past(arr_data)));

    assert_prog_poll_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && op_busy && state == ST_PROG) |=> (bus_q[W-1] == !$past(top_held)));

    assert_erase_poll_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && op_busy && state == ST_ERASE) |=> !bus_q[W-1]);

    assert_toggle_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && op_busy) |=> (tog != $past(tog)));

    assert_released_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_strobe && op_busy) |=> (bus_oe[W-1:W-2] == 2'b11 && bus_oe[W-3:0] == '0
                                    && bus_q[W-3:0] == '0));

    assert_kind_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ERASE && op_busy) |=> (state == ST_ERASE));

    assert_toggle_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !op_busy |=> !tog);

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_strobe |=> ($stable(bus_q) && $stable(bus_oe)));

endmodule

bind poll_status_responder poll_resp_checker #(.W(W)) u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_busy   (op_busy),
    .rd_strobe (rd_strobe),
    .arr_data  (arr_data),
    .bus_q     (bus_q),
    .bus_oe    (bus_oe),
    .state     (state),
    .tog       (tog),
    .top_held  (top_held)
);

// File: tb/test_poll_status_responder.sv
module test_poll_status_responder;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_busy = 1'b0;
    logic       op_is_erase = 1'b0;
    logic       wr_top_bit = 1'b0;
    logic       rd_strobe = 1'b0;
    logic [7:0] arr_data = 8'h00;
    logic [7:0] bus_q;
    logic [7:0] bus_oe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    poll_status_responder #(.W(8)) i_poll_status_responder (
        .clk         (clk),
        .rst_n       (rst_n),
        .op_busy     (op_busy),
        .op_is_erase (op_is_erase),
        .wr_top_bit  (wr_top_bit),
        .rd_strobe   (rd_strobe),
        .arr_data    (arr_data),
        .bus_q       (bus_q),
        .bus_oe      (bus_oe)
    );

    task automatic check(input string req, input logic [7:0] exp_q, input logic [7:0] exp_oe);
        checks++;
        if (bus_q !== exp_q || bus_oe !== exp_oe) begin
            errors++;
            $display("FAIL %s: q=%h oe=%h, expected q=%h oe=%h", req, bus_q, bus_oe, exp_q, exp_oe);
        end
    endtask

    // strobe at a falling edge, result visible at the next falling edge
    task automatic do_read(input logic [7:0] a);
        @(negedge clk);
        arr_data  = a;
        rd_strobe = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
    endtask

    task automatic start_op(input logic erase, input logic top);
        @(negedge clk);
        op_busy     = 1'b1;
        op_is_erase = erase;
        wr_top_bit  = top;
    endtask

    task automatic end_op;
        @(negedge clk);
        op_busy = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 reset", 8'h00, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", 8'h00, 8'h00);
    endtask

    task automatic t_idle;
        do_read(8'hA5);
        check("R2 idle read", 8'hA5, 8'hFF);
        @(negedge clk);
        arr_data = 8'h12;
        repeat (5) @(negedge clk);
        check("R10 hold without strobe", 8'hA5, 8'hFF);
    endtask

    task automatic t_program;
        logic prev6;
        start_op(1'b0, 1'b0);
        @(negedge clk);
        wr_top_bit = 1'b1;          // must be ignored (R3)
        do_read(8'h3C);
        check("R3 R6 program read 1", 8'h80, 8'hC0);
        do_read(8'h3C);
        check("R5 program read 2", 8'hC0, 8'hC0);
        do_read(8'hFF);
        check("R6 program read 3", 8'h80, 8'hC0);
        end_op();
        do_read(8'h3C);
        check("R8 first read after program", 8'h3C, 8'hFF);
        prev6 = bus_q[6];
        do_read(8'h3C);
        check("R8 second read after program", 8'h3C, 8'hFF);
        checks++;
        if (bus_q[6] !== prev6 || bus_q[7] !== 1'b0) begin
            errors++;
            $display("FAIL R8 completion: bit6 %b->%b bit7 %b, expected steady and 0",
                     prev6, bus_q[6], bus_q[7]);
        end
    endtask

    task automatic t_erase;
        start_op(1'b1, 1'b0);
        @(negedge clk);
        op_is_erase = 1'b0;         // must be ignored (R7)
        do_read(8'hFF);
        check("R4 R7 erase read 1", 8'h00, 8'hC0);
        repeat (50) @(negedge clk);
        do_read(8'hFF);
        check("R5 spaced erase read 2", 8'h40, 8'hC0);
        repeat (37) @(negedge clk);
        do_read(8'h55);
        check("R5 spaced erase read 3", 8'h00, 8'hC0);
        end_op();
        do_read(8'hFF);
        check("R8 read after erase", 8'hFF, 8'hFF);
    endtask

    task automatic t_restart;
        // previous program left the toggle after an odd count of reads
        start_op(1'b0, 1'b1);
        @(negedge clk);
        op_busy = 1'b0;
        do_read(8'h01);
        check("R8 read after short op", 8'h01, 8'hFF);
        // busy and strobe in the same cycle
        @(negedge clk);
        op_busy     = 1'b1;
        op_is_erase = 1'b0;
        wr_top_bit  = 1'b1;
        arr_data    = 8'h9F;
        rd_strobe   = 1'b1;
        @(negedge clk);
        rd_strobe = 1'b0;
        check("R9 first busy cycle read", 8'h00, 8'hC0);
        do_read(8'h9F);
        check("R9 second read", 8'h40, 8'hC0);
        do_read(8'h9F);
        check("R9 third read", 8'h00, 8'hC0);
        end_op();
        start_op(1'b0, 1'b1);
        do_read(8'h00);
        check("R9 new op restarts toggle", 8'h00, 8'hC0);
        end_op();
        do_read(8'h80);
        check("R8 final array read", 8'h80, 8'hFF);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_idle();
        t_program();
        t_erase();
        t_restart();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule